// File: doc/BRIEF.md
# A20 Mask Output Controller

This block produces the active-low A20 mask request for the processor. When the mask is asserted (low), the processor folds address bit 20 to zero. Legacy real-mode software depends on this to see addresses wrap around at the 1 MB boundary. Two independent requests can lift the mask. The first is a gate state delivered as decoded codes over a serial control link. The upstream logic ORs its own sources and sends a new code only when that combined value changes, so this block keeps the last value received. The second is a fast-gate bit held in an I/O port.

The mask output shares a pad with a test-mode input. After reset the pad driver is off, so an external pull-up holds the line high. While the driver is off, the block samples the pad, and a low level raises the `test_mode` output. When a configuration bit is set, the driver turns on and the test function is blocked. Registers are written and read over a simple strobed bus. The bus has two spaces: I/O ports and configuration indices.

Top module: `a20_mask_ctrl`

## Requirements
- R1: While reset is held and after it is released, `pad_oe` is 0 and `test_mode` is 0. Both request bits are clear, so `pad_out` is 0 (mask asserted, but not driven). A read of I/O port 92h returns 00h.
- R2: On a cycle with `link_stb` high, the link gate state takes the value of `link_gate` from the next cycle on. While `link_stb` is low, the state holds and changes on `link_gate` are ignored.
- R3: A write in I/O space (`bus_cfg`=0) to address 92h stores `bus_wdata` bit 1 as the fast-gate bit. The other data bits are not stored. A read of port 92h returns the stored bit in bit 1, with every other bit 0.
- R4: `pad_out` is 1 (mask released) when the link gate state or the fast-gate bit is 1. It is 0 when both are 0. It follows a register change from the cycle after the write or strobe.
- R5: A write in configuration space (`bus_cfg`=1) to index 09h stores `bus_wdata` bit 4 as the driver enable. `pad_oe` equals the stored bit from the next cycle on. A read of index 09h returns that bit in bit 4, with every other bit 0.
- R6: While the driver enable is 0, `test_mode` equals the inversion of `pad_in` through a two-stage synchronizer and one output register. A level change on `pad_in` shows on `test_mode` three cycles later.
- R7: Once the driver enable is 1, `test_mode` is 0 from the cycle after the enable register is set, whatever `pad_in` does.
- R8: Writes to any other address or index, and writes to address 92h or index 09h in the wrong space, change no state. Reads of unmapped locations return 00h.
- R9: A link strobe and a register write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cfg | input | 1 | Space select: 1 = configuration index, 0 = I/O port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid in the same cycle |
| bus_addr | input | 8 | I/O address or configuration index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 00h when `bus_rd` is low |
| link_stb | input | 1 | Decoded gate-A20 link code is present |
| link_gate | input | 1 | Gate state carried by the link code (1 = enable A20) |
| pad_out | output | 1 | Pad output value, active-low A20 mask |
| pad_oe | output | 1 | Pad output enable |
| pad_in | input | 1 | Pad input level, used as the test-mode request |
| test_mode | output | 1 | Registered test-mode indication |

## Verification
The assertions assume a one-cycle `bus_wr` pulse per access, with `bus_cfg`, `bus_addr` and `bus_wdata` stable in that cycle. They also assume `link_gate` is valid whenever `link_stb` is high and that reset is asserted at time zero. The stimulus drives every input on the falling clock edge from tasks. It holds reset from the first instant. It never raises a read and a write together, so every strobe sees settled data. `pad_in` may change at any falling edge, because the block synchronizes it.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam int unsigned BUS_AW       = 8;
  localparam int unsigned BUS_DW       = 8;
  localparam logic [7:0]  FAST_PORT    = 8'h92;
  localparam int unsigned FAST_BIT     = 1;
  localparam logic [7:0]  DRV_INDEX    = 8'h09;
  localparam int unsigned DRV_BIT      = 4;
  localparam int unsigned SYNC_STAGES  = 2;
endpackage

// File: rtl/a20_sync_chain.sv
module a20_sync_chain #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_next
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RESET_VAL;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/a20_req_regs.sv
module a20_req_regs #(
  parameter int unsigned AW        = a20_pkg::BUS_AW,
  parameter int unsigned DW        = a20_pkg::BUS_DW,
  parameter logic [AW-1:0] FAST_ADDR = AW'(a20_pkg::FAST_PORT),
  parameter int unsigned FAST_POS  = a20_pkg::FAST_BIT,
  parameter logic [AW-1:0] DRV_IDX = AW'(a20_pkg::DRV_INDEX),
  parameter int unsigned DRV_POS   = a20_pkg::DRV_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cfg,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          link_stb,
  input  logic          link_gate,
  output logic          req_link,
  output logic          req_fast,
  output logic          drv_en
);
  logic hit_fast, hit_drv;
  logic link_q, link_d, link_ce;
  logic fast_q, fast_d, fast_ce;
  logic en_q, en_d, en_ce;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign hit_fast = !bus_cfg && (bus_addr == FAST_ADDR);
  assign hit_drv  =  bus_cfg && (bus_addr == DRV_IDX);

  always_comb begin
    link_ce = link_stb;
    link_d  = link_gate;
    fast_ce = bus_wr && hit_fast;
    fast_d  = bus_wdata[FAST_POS];
    en_ce   = bus_wr && hit_drv;
    en_d    = bus_wdata[DRV_POS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      fast_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (link_ce) link_q <= link_d;
      if (fast_ce) fast_q <= fast_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_fast) bus_rdata[FAST_POS] = fast_q;
      if (hit_drv)  bus_rdata[DRV_POS]  = en_q;
    end
  end

  assign req_link = link_q;
  assign req_fast = fast_q;
  assign drv_en   = en_q;

  assert_link_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    link_stb |=> (req_link == $past(link_gate)));
  assert_link_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_stb |=> $stable(req_link));
  assert_fast_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_cfg && bus_addr == FAST_ADDR) |=> (req_fast == $past(bus_wdata[FAST_POS])));
  assert_cfg_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_cfg) |=> $stable(drv_en));
endmodule

// File: rtl/a20_pad_ctrl.sv
module a20_pad_ctrl #(
  parameter int unsigned STAGES = a20_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_link,
  input  logic req_fast,
  input  logic drv_en,
  input  logic pad_in,
  output logic pad_out,
  output logic pad_oe,
  output logic test_mode
);
  logic pad_sync;
  logic tm_q, tm_d;

  a20_sync_chain #(.STAGES(STAGES), .RESET_VAL(1'b1)) u_pad_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  always_comb begin
    tm_d = !drv_en && !pad_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tm_q <= 1'b0;
    else        tm_q <= tm_d;
  end

  assign pad_out   = req_link | req_fast;
  assign pad_oe    = drv_en;
  assign test_mode = tm_q;

  assert_test_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |=> !test_mode);
  assert_mask_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_link || req_fast) |-> pad_out);
endmodule

// File: rtl/a20_mask_ctrl.sv
module a20_mask_ctrl #(
  parameter int unsigned AW     = a20_pkg::BUS_AW,
  parameter int unsigned DW     = a20_pkg::BUS_DW,
  parameter int unsigned STAGES = a20_pkg::SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cfg,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          link_stb,
  input  logic          link_gate,
  output logic          pad_out,
  output logic          pad_oe,
  input  logic          pad_in,
  output logic          test_mode
);
  logic rst_sync_n;
  logic req_link, req_fast, drv_en;

  a20_sync_chain #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  a20_req_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_cfg   (bus_cfg),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .link_stb  (link_stb),
    .link_gate (link_gate),
    .req_link  (req_link),
    .req_fast  (req_fast),
    .drv_en    (drv_en)
  );

  a20_pad_ctrl #(.STAGES(STAGES)) u_pad (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_link  (req_link),
    .req_fast  (req_fast),
    .drv_en    (drv_en),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .test_mode (test_mode)
  );

  assert_oe_follows_cfg_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_cfg && bus_addr == AW'(a20_pkg::DRV_INDEX)) |=> (pad_oe == $past(bus_wdata[a20_pkg::DRV_BIT])));
  assert_reset_float_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!pad_oe && !test_mode));
endmodule

// File: tb/a20_mask_ctrl_bench.sv
module a20_mask_ctrl_bench;
  typedef struct {
    string      tag;
    logic       out;
    logic       oe;
    logic       tm;
    bit         chk_rd;
    logic [7:0] rd;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic       bus_cfg, bus_wr, bus_rd;
  logic [7:0] bus_addr, bus_wdata;
  logic [7:0] bus_rdata;
  logic       link_stb, link_gate;
  logic       pad_out, pad_oe, pad_in, test_mode;

  item_t exp_q[$];
  int    checks;
  int    failures;
  bit    done;

  logic  m_link, m_fast, m_en, m_tm;

  a20_mask_ctrl u_a20_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_cfg(bus_cfg), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .link_stb(link_stb), .link_gate(link_gate), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .test_mode(test_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic push(input string tag, input bit chk_rd, input logic [7:0] rd);
    item_t it;
    it.tag = tag; it.out = m_link | m_fast; it.oe = m_en; it.tm = m_tm;
    it.chk_rd = chk_rd; it.rd = rd;
    exp_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (pad_out !== it.out || pad_oe !== it.oe || test_mode !== it.tm ||
            (it.chk_rd && bus_rdata !== it.rd)) begin
          failures++;
          $display("FAIL %s: out/oe/tm/rd actual %b%b%b %h expected %b%b%b %h",
                   it.tag, pad_out, pad_oe, test_mode, bus_rdata,
                   it.out, it.oe, it.tm, it.chk_rd ? it.rd : bus_rdata);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit cfg, input logic [7:0] a, input logic [7:0] d);
    bus_cfg = cfg; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(input bit cfg, input logic [7:0] a, input logic [7:0] e, input string tag);
    bus_cfg = cfg; bus_addr = a; bus_rd = 1'b1;
    push(tag, 1'b1, e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic link(input logic g);
    link_gate = g; link_stb = 1'b1;
    @(negedge clk);
    link_stb = 1'b0; link_gate = ~g;
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; bus_cfg = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    link_stb = 0; link_gate = 0; pad_in = 1'b1;
    m_link = 0; m_fast = 0; m_en = 0; m_tm = 0;
    idle(3);
    push("R1 during reset", 1'b0, 8'h00);
    idle(1);
    rst_n = 1'b1;
    idle(4);
    push("R1 after reset", 1'b0, 8'h00);
    rd(1'b0, 8'h92, 8'h00, "R1 port read");

    pad_in = 1'b0;
    idle(2); push("R6 not yet", 1'b0, 8'h00);
    idle(1); m_tm = 1; push("R6 test seen", 1'b0, 8'h00);
    pad_in = 1'b1;
    idle(3); m_tm = 0; push("R6 test gone", 1'b0, 8'h00);

    link(1'b1); m_link = 1; push("R2 R4 link set", 1'b0, 8'h00);
    link_gate = 1'b0; idle(3); link_gate = 1'b1; idle(1);
    push("R2 hold", 1'b0, 8'h00);
    link(1'b0); m_link = 0; push("R2 link clear", 1'b0, 8'h00);

    wr(1'b0, 8'h92, 8'h02); m_fast = 1; push("R3 R4 fast set", 1'b0, 8'h00);
    rd(1'b0, 8'h92, 8'h02, "R3 read one");
    wr(1'b0, 8'h92, 8'hFD); m_fast = 0; push("R3 other bits", 1'b0, 8'h00);
    rd(1'b0, 8'h92, 8'h00, "R3 read zero");

    link(1'b1); m_link = 1;
    wr(1'b0, 8'h92, 8'h02); m_fast = 1; push("R4 both", 1'b0, 8'h00);
    link(1'b0); m_link = 0; push("R4 fast only", 1'b0, 8'h00);
    wr(1'b0, 8'h92, 8'h00); m_fast = 0; push("R4 none", 1'b0, 8'h00);

    wr(1'b0, 8'h93, 8'hFF); rd(1'b0, 8'h92, 8'h00, "R8 other port");
    wr(1'b1, 8'h92, 8'hFF); push("R8 cfg space 92", 1'b0, 8'h00);
    wr(1'b1, 8'h09, 8'hEF); push("R8 bit4 clear", 1'b0, 8'h00);
    wr(1'b0, 8'h09, 8'h10); push("R8 io space 09", 1'b0, 8'h00);
    rd(1'b1, 8'h0A, 8'h00, "R8 unmapped read");

    pad_in = 1'b0; idle(3); m_tm = 1; push("R6 test again", 1'b0, 8'h00);
    wr(1'b1, 8'h09, 8'h10); m_en = 1; push("R5 oe on", 1'b0, 8'h00);
    idle(1); m_tm = 0; push("R7 test blocked", 1'b0, 8'h00);
    rd(1'b1, 8'h09, 8'h10, "R5 cfg read");
    pad_in = 1'b1; idle(2); pad_in = 1'b0; idle(5);
    push("R7 pad ignored", 1'b0, 8'h00);

    wr(1'b0, 8'h92, 8'h02); m_fast = 1;
    link_gate = 1'b1; link_stb = 1'b1;
    bus_cfg = 1'b0; bus_addr = 8'h92; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; link_stb = 1'b0;
    m_link = 1; m_fast = 0; push("R9 same cycle", 1'b0, 8'h00);
    rd(1'b0, 8'h92, 8'h00, "R9 fast cleared");
    link(1'b0); m_link = 0; push("R9 link cleared", 1'b0, 8'h00);

    wr(1'b1, 8'h09, 8'h00); m_en = 0; push("R5 oe off", 1'b0, 8'h00);
    idle(1); m_tm = 1; push("R6 test resumes", 1'b0, 8'h00);

    idle(2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule